// File: doc/BRIEF.md
# Cipher Key-Load and Launch Register Interface

This block is a word-wide slave register interface through which a processor prepares a stream-cipher core. Four 32-bit registers are decoded from a two-bit word address: an output word, a data word, a status word and a control word. Software first places a value in the data register. It then writes the control register with a command in the top byte and a slot index in the low byte. That control write copies the held data word into one slot of a three-word key store or a three-word IV store. Because the data register holds its value, one data write can feed several slots.

Launching the key schedule is a control write whose command is the start code. The block answers with a one-cycle start pulse toward the core. The pulse comes only when the control register held some other command before, so repeated start writes do not relaunch the core. A small state machine tracks this. ST_IDLE means the last command was not start. ST_FIRE is the single pulse cycle. ST_HOLD means the start command is still held. The transitions are: IDLE→FIRE on a start write; FIRE→IDLE on a non-start write in that cycle, otherwise FIRE→HOLD; HOLD→IDLE on a non-start write. The status register shows the core's busy line and a sticky completion flag. The output register captures the core's result word when the core signals completion.

Top module: `cipher_mmio_if`

## Requirements
- R1: After reset every register reads zero, both stores are zero and the start pulse is low.
- R2: A write to word 1 sets the data register, which reads back at word 1 and keeps its value until the next data write; word 3 reads back the last control word.
- R3: A control write with command 1 (bits 31:24) stores the data register into IV slot k, and command 2 stores it into key slot k, where k is bits 7:0. Slot k appears on bits 32k+31:32k of the store outputs, and the change is visible one cycle after the write.
- R4: One data write followed by control writes to slots 0, 1 and 2 loads the same word into all three slots.
- R5: A store command with an index of 3 or more changes no store word.
- R6: Store commands written while the core reports busy change no store word.
- R7: A control write with command 3, when the previous control command was not 3, drives the start output high for exactly the one cycle after the write.
- R8: A command-3 write while the previous control command is already 3 produces no start pulse.
- R9: Status bit 0 follows the core's busy input. Status bit 1 becomes 1 in the cycle after the core's done input is high, and clears in the cycle after a start pulse.
- R10: The output register (word 0) captures the core's result word in the cycle after the core's done input is high, and holds it otherwise.
- R11: Control commands other than 1 and 2 (for example 0, 4 to 15 and 255) change no store word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 2 | Word address: 0 output, 1 data, 2 status, 3 control |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register (combinational) |
| core_busy | input | 1 | Core is running the key schedule |
| core_done | input | 1 | Core completion, one cycle |
| core_word | input | 32 | Core result word |
| core_start | output | 1 | One-cycle key-schedule start |
| key_words | output | 96 | Key store, slot 0 in the low word |
| iv_words | output | 96 | IV store, slot 0 in the low word |

## Verification
Register and store updates land on the clock edge that takes the write, so the bench samples them at the falling edge right after that write. The start pulse comes from a registered state and is high from the write edge to the next edge. Status bit 1 and the output register change one edge after the core stub raises done, and the stub's busy line rises one edge after the pulse. Each check waits exactly that number of falling edges, counted from the write, before it samples.

// File: rtl/cmi_pkg.sv
package cmi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FIRE = 2'd1,
        ST_HOLD = 2'd2
    } start_state_t;

    localparam logic [7:0] CMD_IV    = 8'd1;
    localparam logic [7:0] CMD_KEY   = 8'd2;
    localparam logic [7:0] CMD_START = 8'd3;

    localparam logic [1:0] OFS_OUT  = 2'd0;
    localparam logic [1:0] OFS_DATA = 2'd1;
    localparam logic [1:0] OFS_STAT = 2'd2;
    localparam logic [1:0] OFS_CTRL = 2'd3;
endpackage

// File: rtl/cmi_regs.sv
module cmi_regs #(
    parameter int WORD_W  = 32,
    parameter int N_WORDS = 3,
    parameter int CMD_W   = 8,
    parameter int IDX_W   = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      data_we,
    input  logic                      ctrl_we,
    input  logic [WORD_W-1:0]         wdata,
    input  logic                      core_busy,
    output logic [WORD_W-1:0]         data_q,
    output logic [WORD_W-1:0]         ctrl_q,
    output logic [N_WORDS*WORD_W-1:0] key_q,
    output logic [N_WORDS*WORD_W-1:0] iv_q
);
    import cmi_pkg::*;

    localparam int CMD_LSB = WORD_W - CMD_W;

    logic [CMD_W-1:0] wr_cmd;
    logic [IDX_W-1:0] wr_idx;
    logic             key_sel;
    logic             iv_sel;

    assign wr_cmd  = wdata[CMD_LSB +: CMD_W];
    assign wr_idx  = wdata[IDX_W-1:0];
    assign key_sel = ctrl_we && !core_busy && (wr_cmd == CMD_KEY);
    assign iv_sel  = ctrl_we && !core_busy && (wr_cmd == CMD_IV);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            ctrl_q <= '0;
        end else begin
            if (data_we) data_q <= wdata;
            if (ctrl_we) ctrl_q <= wdata;
        end
    end

    for (genvar i = 0; i < N_WORDS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                key_q[i*WORD_W +: WORD_W] <= '0;
                iv_q[i*WORD_W +: WORD_W]  <= '0;
            end else begin
                if (key_sel && wr_idx == IDX_W'(i))
                    key_q[i*WORD_W +: WORD_W] <= data_q;
                if (iv_sel && wr_idx == IDX_W'(i))
                    iv_q[i*WORD_W +: WORD_W] <= data_q;
            end
        end
    end

    AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !data_we |=> $stable(data_q)); // R2
    AST_BUSY_FREEZES_STORES: assert property (@(posedge clk) disable iff (!rst_n)
        core_busy |=> ($stable(key_q) && $stable(iv_q))); // R6
    AST_BAD_INDEX_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && wr_idx >= IDX_W'(N_WORDS)) |=> ($stable(key_q) && $stable(iv_q))); // R5
    AST_OTHER_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && wr_cmd != CMD_KEY && wr_cmd != CMD_IV) |=> ($stable(key_q) && $stable(iv_q))); // R11
endmodule

// File: rtl/cmi_start_fsm.sv
module cmi_start_fsm #(
    parameter int WORD_W = 32,
    parameter int CMD_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [CMD_W-1:0]  wr_cmd,
    input  logic              core_done,
    input  logic [WORD_W-1:0] core_word,
    output logic              core_start,
    output logic              done_q,
    output logic [WORD_W-1:0] out_q
);
    import cmi_pkg::*;

    start_state_t state_q;
    start_state_t state_d;
    logic         start_wr;
    logic         other_wr;

    assign start_wr = ctrl_we && (wr_cmd == CMD_START);
    assign other_wr = ctrl_we && (wr_cmd != CMD_START);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_wr) state_d = ST_FIRE;
            ST_FIRE: state_d = other_wr ? ST_IDLE : ST_HOLD;
            ST_HOLD: if (other_wr) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        core_start = 1'b0;
        unique case (state_q)
            ST_IDLE: core_start = 1'b0;
            ST_FIRE: core_start = 1'b1;
            ST_HOLD: core_start = 1'b0;
            default: core_start = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            out_q  <= '0;
        end else begin
            if (core_start)     done_q <= 1'b0;
            else if (core_done) done_q <= 1'b1;
            if (core_done) out_q <= core_word;
        end
    end

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |=> !core_start); // R7
    AST_START_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |-> $past(start_wr)); // R7
    AST_DONE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |=> !done_q); // R9
    AST_OUT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        core_done |=> (out_q == $past(core_word))); // R10
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !core_done |=> $stable(out_q)); // R10
endmodule

// File: rtl/cipher_mmio_if.sv
module cipher_mmio_if #(
    parameter int WORD_W  = 32,
    parameter int N_WORDS = 3,
    parameter int CMD_W   = 8,
    parameter int IDX_W   = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_we,
    input  logic [1:0]                bus_addr,
    input  logic [WORD_W-1:0]         bus_wdata,
    output logic [WORD_W-1:0]         bus_rdata,
    input  logic                      core_busy,
    input  logic                      core_done,
    input  logic [WORD_W-1:0]         core_word,
    output logic                      core_start,
    output logic [N_WORDS*WORD_W-1:0] key_words,
    output logic [N_WORDS*WORD_W-1:0] iv_words
);
    import cmi_pkg::*;

    localparam int CMD_LSB = WORD_W - CMD_W;

    logic              data_we;
    logic              ctrl_we;
    logic [WORD_W-1:0] data_q;
    logic [WORD_W-1:0] ctrl_q;
    logic [WORD_W-1:0] out_q;
    logic              done_q;
    logic [CMD_W-1:0]  wr_cmd;
    logic [CMD_W-1:0]  held_cmd;

    assign data_we  = bus_we && (bus_addr == OFS_DATA);
    assign ctrl_we  = bus_we && (bus_addr == OFS_CTRL);
    assign wr_cmd   = bus_wdata[CMD_LSB +: CMD_W];
    assign held_cmd = ctrl_q[CMD_LSB +: CMD_W];

    cmi_regs #(
        .WORD_W(WORD_W), .N_WORDS(N_WORDS), .CMD_W(CMD_W), .IDX_W(IDX_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .data_we(data_we), .ctrl_we(ctrl_we),
        .wdata(bus_wdata), .core_busy(core_busy), .data_q(data_q),
        .ctrl_q(ctrl_q), .key_q(key_words), .iv_q(iv_words)
    );

    cmi_start_fsm #(
        .WORD_W(WORD_W), .CMD_W(CMD_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .wr_cmd(wr_cmd),
        .core_done(core_done), .core_word(core_word),
        .core_start(core_start), .done_q(done_q), .out_q(out_q)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_OUT:  bus_rdata = out_q;
            OFS_DATA: bus_rdata = data_q;
            OFS_STAT: bus_rdata = {{(WORD_W-2){1'b0}}, done_q, core_busy};
            OFS_CTRL: bus_rdata = ctrl_q;
            default:  bus_rdata = '0;
        endcase
    end

    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && wr_cmd == CMD_START && held_cmd == CMD_START) |=> !core_start); // R8
    AST_FRESH_START: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && wr_cmd == CMD_START && held_cmd != CMD_START) |=> core_start); // R7
endmodule

// File: tb/sim_cipher_mmio_if.sv
module sim_cipher_mmio_if;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        core_busy;
    logic        core_done;
    logic [31:0] core_word = 32'h0;
    logic        core_start;
    logic [95:0] key_words;
    logic [95:0] iv_words;

    int tests = 0;
    int fails = 0;
    int pulses = 0;
    logic [2:0]  stub_cnt = 3'd0;
    logic [95:0] mk = '0;
    logic [95:0] mi = '0;
    logic [31:0] rv;

    always #4 clk = ~clk;

    assign core_busy = (stub_cnt != 3'd0);
    assign core_done = (stub_cnt == 3'd1);

    always @(posedge clk) begin
        if (!rst_n) stub_cnt <= 3'd0;
        else if (core_start) stub_cnt <= 3'd4;
        else if (stub_cnt != 3'd0) stub_cnt <= stub_cnt - 3'd1;
        if (rst_n && core_start) pulses <= pulses + 1;
    end

    cipher_mmio_if u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_busy(core_busy),
        .core_done(core_done), .core_word(core_word), .core_start(core_start),
        .key_words(key_words), .iv_words(iv_words)
    );

    task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic stores(input string req);
        check(req, key_words, mk);
        check(req, iv_words, mi);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), rv);
            check("R1 read", {64'h0, rv}, 96'h0);
        end
        stores("R1 stores");
        check("R1 start", {95'h0, core_start}, 96'h0);

        // R2: data holds, control reads back
        wr(2'd1, 32'hA5A5_0F0F);
        rd(2'd1, rv); check("R2 data", {64'h0, rv}, {64'h0, 32'hA5A5_0F0F});
        wr(2'd3, 32'h0000_0007);
        rd(2'd1, rv); check("R2 data held", {64'h0, rv}, {64'h0, 32'hA5A5_0F0F});
        rd(2'd3, rv); check("R2 ctrl", {64'h0, rv}, {64'h0, 32'h0000_0007});
        stores("R2 stores");

        // R3 / R5: sweep commands 1,2 over indices 0..5
        for (int c = 1; c <= 2; c++) begin
            for (int k = 0; k < 6; k++) begin
                logic [31:0] d;
                d = 32'h1000_0000 * c + 32'h0101 * k + 32'h55;
                wr(2'd1, d);
                wr(2'd3, (32'(c) << 24) | 32'(k));
                if (k < 3) begin
                    if (c == 2) mk[k*32 +: 32] = d;
                    else        mi[k*32 +: 32] = d;
                    stores("R3 slot write");
                end else begin
                    stores("R5 index out of range");
                end
            end
        end

        // R4: one data word into all key slots
        wr(2'd1, 32'hCAFE_F00D);
        for (int k = 0; k < 3; k++) begin
            wr(2'd3, (32'd2 << 24) | 32'(k));
            mk[k*32 +: 32] = 32'hCAFE_F00D;
        end
        stores("R4 shared data");

        // R11: other commands ignored
        wr(2'd1, 32'hDEAD_BEEF);
        for (int c = 0; c < 16; c++) begin
            if (c != 1 && c != 2 && c != 3) begin
                wr(2'd3, (32'(c) << 24) | 32'd1);
                stores("R11 other command");
            end
        end
        wr(2'd3, 32'hFF00_0000);
        stores("R11 command 255");

        // R7 / R9 / R6 / R10: first launch
        core_word = 32'h1234_5678;
        wr(2'd3, 32'h0000_0000);
        wr(2'd3, 32'h0300_0000);
        check("R7 pulse high", {95'h0, core_start}, 96'h1);
        @(negedge clk);
        check("R7 pulse one cycle", {95'h0, core_start}, 96'h0);
        rd(2'd2, rv); check("R9 busy", {64'h0, rv}, 96'h1);
        wr(2'd1, 32'h7777_7777);
        wr(2'd3, 32'h0200_0000);
        stores("R6 write while busy");
        @(negedge clk); @(negedge clk);
        rd(2'd2, rv); check("R9 done set", {64'h0, rv}, 96'h2);
        rd(2'd0, rv); check("R10 output", {64'h0, rv}, {64'h0, 32'h1234_5678});
        core_word = 32'h0BAD_0BAD;
        @(negedge clk);
        rd(2'd0, rv); check("R10 output held", {64'h0, rv}, {64'h0, 32'h1234_5678});

        // second launch: previous command was 2, done clears
        core_word = 32'h9ABC_DEF0;
        wr(2'd3, 32'h0300_0000);
        check("R7 pulse after cmd 2", {95'h0, core_start}, 96'h1);
        @(negedge clk);
        rd(2'd2, rv); check("R9 done cleared", {64'h0, rv}, 96'h1);
        repeat (4) @(negedge clk);
        rd(2'd2, rv); check("R9 done again", {64'h0, rv}, 96'h2);
        rd(2'd0, rv); check("R10 output 2", {64'h0, rv}, {64'h0, 32'h9ABC_DEF0});

        // R8: repeated start command
        wr(2'd3, 32'h0300_0000);
        check("R8 no retrigger", {95'h0, core_start}, 96'h0);
        @(negedge clk);
        check("R8 no retrigger late", {95'h0, core_start}, 96'h0);
        rd(2'd2, rv); check("R8 status idle", {64'h0, rv}, 96'h2);
        wr(2'd3, 32'h0000_0000);
        wr(2'd3, 32'h0300_0000);
        check("R7 relaunch", {95'h0, core_start}, 96'h1);
        repeat (6) @(negedge clk);
        check("R7 R8 pulse count", 96'(pulses), 96'd3);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule